// File: doc/BRIEF.md
# SAR ADC Sequencing Controller

This block is the digital half of an 8-bit successive-approximation converter peripheral. Software programs it through a small register bus. That bus carries a control word, a per-pin analog-enable mask, a reference-select bit and a read-only result. The block steers the analog multiplexer with a latched channel code. It pulses a sample-and-hold strobe for a fixed number of cycles, then walks a trial code for the resistor ladder from the most significant bit down. At each step it keeps or drops the bit according to a single comparator decision. At the end it loads the result, raises a ready status and raises a sticky interrupt flag on the same clock edge.

The sequencer has four states. IDLE moves to SAMPLE when a start request is accepted. A request is accepted when the start bit is set, the converter is enabled and the chosen channel is legal. SAMPLE holds the strobe and moves to CONVERT after `SH_CYCLES` cycles. CONVERT resolves one bit per cycle and moves to DONE after the least significant trial. DONE loads the result and always returns to IDLE. SAMPLE and CONVERT both fall back to IDLE at once if the enable bit is cleared.

A start is refused, and a sticky reject flag is set, in two cases. The first is a channel whose analog-enable bit is clear. The second is channel 0 while the external reference is selected, because that reference shares its pin with input 0.

Top module: `sar_seq_ctrl`

## Requirements
- R1: Bits [2:0] of the control register (address 0) choose the channel. Code 0 selects input 0 and code 7 selects input 7. `chan_o` holds the code captured when the start is accepted, for the whole conversion.
- R2: The analog-enable mask (address 2, bit i for input i) gates conversions. A start on a channel whose bit is 0 does not convert and sets the reject flag (control bit 7).
- R3: The start bit (control bit 3) reads 1 in the cycle after it is written with 1. It reads 0 from the cycle after that.
- R4: A conversion holds `sh_o` high for exactly `SH_CYCLES` cycles with `trial_o` at 0. It then runs DATA_W trial cycles starting from trial code 0x80, most significant bit first. A bit is kept when `cmp_i` is 1 (input at or above the trial code) and cleared otherwise. With an ideal comparator, the result equals the input code.
- R5: The ready status (control bit 5, `ready_o`) falls on the edge that accepts a start. `result_o` keeps its previous value until completion.
- R6: On completion, the result register (address 1, `result_o`) is loaded and ready and the interrupt flag both go to 1, all on one clock edge.
- R7: The reference-select bit (address 3, bit 0) chooses the external reference when it is 1. In that mode `ana_en_o[0]` is forced to 0 and a start on channel 0 is refused with the reject flag set. Other channels still convert.
- R8: `ready_o` rises `SH_CYCLES`+10 clocks after the clock edge that writes the start bit. That is 14 clocks at default parameters, well within 80.
- R9: The interrupt flag (control bit 6) and the reject flag (bit 7) stay set until a control write carries 0 in that bit. A write carrying 1 leaves them unchanged.
- R10: A start written while a conversion is running is ignored. Exactly one completion occurs, with the first channel's result.
- R11: With the enable bit (control bit 4) at 0, a start neither converts nor sets the reject flag. Clearing the enable bit during SAMPLE or CONVERT returns the sequencer to IDLE with no completion, so ready stays 0 and the result is unchanged.
- R12: After reset, every register reads 0 and `sh_o`, `trial_o`, `ready_o`, `irq_o`, `result_o` and `ana_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| cmp_i | input | 1 | Comparator decision: 1 when input is at or above `trial_o` |
| chan_o | output | CH_W (3) | Analog multiplexer channel select |
| sh_o | output | 1 | Sample-and-hold strobe |
| trial_o | output | DATA_W (8) | Trial code for the resistor ladder |
| ana_en_o | output | N_CH (8) | Effective per-pin analog enables |
| result_o | output | DATA_W (8) | Last conversion result |
| ready_o | output | 1 | Conversion-complete status |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with eight channels and 8-bit resolution, but with `SH_CYCLES` set to 5 instead of the default 4. This shows that the completion latency and the strobe width follow the parameter rather than a hard-coded count. The expected latency therefore becomes 15 clocks. Keeping the full 8-bit code range puts the extreme codes 0x00 and 0xFF, the half-scale neighbours 0x7F and 0x80, and every one of the eight channel codes within reach of the comparator model.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
    localparam int ADDR_W = 2;
    localparam int BUS_W  = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RESULT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_AEN    = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_REF    = 2'd3;

    localparam int BIT_GO    = 3;
    localparam int BIT_EN    = 4;
    localparam int BIT_READY = 5;
    localparam int BIT_IRQ   = 6;
    localparam int BIT_REJ   = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CONVERT,
        ST_DONE
    } sar_state_e;
endpackage

// File: rtl/sar_regs.sv
`timescale 1ns/1ps
module sar_regs
    import sar_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int DATA_W = 8,
    localparam int CH_W  = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    input  logic              accept,
    input  logic              reject,
    input  logic              load,
    input  logic [DATA_W-1:0] code,
    output logic [CH_W-1:0]   chan_field,
    output logic              go,
    output logic              enable,
    output logic [N_CH-1:0]   aen,
    output logic              ext_ref,
    output logic [DATA_W-1:0] result,
    output logic              ready,
    output logic              irq,
    output logic              rej_flag
);
    logic [CH_W-1:0]   chan_q;
    logic              go_q, en_q, ref_q, ready_q, irq_q, rej_q;
    logic [N_CH-1:0]   aen_q;
    logic [DATA_W-1:0] result_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q   <= '0;
            go_q     <= 1'b0;
            en_q     <= 1'b0;
            ref_q    <= 1'b0;
            aen_q    <= '0;
            result_q <= '0;
            ready_q  <= 1'b0;
            irq_q    <= 1'b0;
            rej_q    <= 1'b0;
        end else begin
            go_q <= 1'b0;
            if (wr_en) begin
                unique case (wr_addr)
                    ADDR_CTRL: begin
                        chan_q <= wr_data[CH_W-1:0];
                        go_q   <= wr_data[BIT_GO];
                        en_q   <= wr_data[BIT_EN];
                        if (!wr_data[BIT_IRQ]) irq_q <= 1'b0;
                        if (!wr_data[BIT_REJ]) rej_q <= 1'b0;
                    end
                    ADDR_RESULT: ;
                    ADDR_AEN:    aen_q <= wr_data[N_CH-1:0];
                    ADDR_REF:    ref_q <= wr_data[0];
                endcase
            end
            if (accept) ready_q <= 1'b0;
            if (reject) rej_q   <= 1'b1;
            if (load) begin
                result_q <= code;
                ready_q  <= 1'b1;
                irq_q    <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[CH_W-1:0] = chan_q;
                rd_data[BIT_GO]    = go_q;
                rd_data[BIT_EN]    = en_q;
                rd_data[BIT_READY] = ready_q;
                rd_data[BIT_IRQ]   = irq_q;
                rd_data[BIT_REJ]   = rej_q;
            end
            ADDR_RESULT: rd_data[DATA_W-1:0] = result_q;
            ADDR_AEN:    rd_data[N_CH-1:0]   = aen_q;
            ADDR_REF:    rd_data[0]          = ref_q;
        endcase
    end

    assign chan_field = chan_q;
    assign go         = go_q;
    assign enable     = en_q;
    assign aen        = aen_q;
    assign ext_ref    = ref_q;
    assign result     = result_q;
    assign ready      = ready_q;
    assign irq        = irq_q;
    assign rej_flag   = rej_q;
endmodule

// File: rtl/sar_fsm.sv
`timescale 1ns/1ps
module sar_fsm
    import sar_pkg::*;
#(
    parameter int N_CH      = 8,
    parameter int DATA_W    = 8,
    parameter int SH_CYCLES = 4,
    localparam int CH_W     = $clog2(N_CH),
    localparam int BIT_W    = $clog2(DATA_W),
    localparam int SH_W     = (SH_CYCLES > 1) ? $clog2(SH_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              enable,
    input  logic [CH_W-1:0]   chan_field,
    input  logic [N_CH-1:0]   aen,
    input  logic              ext_ref,
    input  logic              cmp_i,
    output logic              accept,
    output logic              reject,
    output logic              load,
    output logic [DATA_W-1:0] code,
    output logic [CH_W-1:0]   chan_o,
    output logic              sh_o,
    output logic [DATA_W-1:0] trial_o
);
    localparam logic [SH_W-1:0]  SH_LAST = SH_W'(SH_CYCLES - 1);
    localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(DATA_W - 1);

    sar_state_e        state_q, state_d;
    logic [SH_W-1:0]   sh_cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] code_q;
    logic [CH_W-1:0]   chan_q;
    logic              legal;

    // channel is legal when its pin is analog and does not carry the reference
    assign legal  = aen[chan_field] && !(ext_ref && (chan_field == '0));
    assign accept = (state_q == ST_IDLE) && go && enable && legal;
    assign reject = (state_q == ST_IDLE) && go && enable && !legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_SAMPLE;
            ST_SAMPLE: begin
                if (!enable)                  state_d = ST_IDLE;
                else if (sh_cnt_q == SH_LAST) state_d = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (!enable)          state_d = ST_IDLE;
                else if (bit_q == '0) state_d = ST_DONE;
            end
            ST_DONE:    state_d = ST_IDLE;
        endcase
    end

    // sequencing datapath: sample counter, bit pointer, trial code, channel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_cnt_q <= '0;
            bit_q    <= '0;
            code_q   <= '0;
            chan_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        chan_q   <= chan_field;
                        sh_cnt_q <= '0;
                        code_q   <= '0;
                    end
                end
                ST_SAMPLE: begin
                    sh_cnt_q <= sh_cnt_q + 1'b1;
                    if (sh_cnt_q == SH_LAST) begin
                        code_q          <= '0;
                        code_q[MSB_IDX] <= 1'b1;
                        bit_q           <= MSB_IDX;
                    end
                end
                ST_CONVERT: begin
                    code_q[bit_q] <= cmp_i;
                    if (bit_q != '0) begin
                        code_q[bit_q - 1'b1] <= 1'b1;
                        bit_q                <= bit_q - 1'b1;
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    always_comb begin
        sh_o    = (state_q == ST_SAMPLE);
        trial_o = (state_q == ST_CONVERT) ? code_q : '0;
        load    = (state_q == ST_DONE);
        code    = code_q;
        chan_o  = chan_q;
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
    import sar_pkg::*;
#(
    parameter int N_CH      = 8,
    parameter int DATA_W    = 8,
    parameter int SH_CYCLES = 4,
    localparam int CH_W     = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    input  logic              cmp_i,
    output logic [CH_W-1:0]   chan_o,
    output logic              sh_o,
    output logic [DATA_W-1:0] trial_o,
    output logic [N_CH-1:0]   ana_en_o,
    output logic [DATA_W-1:0] result_o,
    output logic              ready_o,
    output logic              irq_o
);
    logic              accept_w, reject_w, load_w;
    logic [DATA_W-1:0] code_w;
    logic [CH_W-1:0]   chan_field_w;
    logic              go_w, en_w, ref_w, rej_w;
    logic [N_CH-1:0]   aen_w;

    sar_regs #(.N_CH(N_CH), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .accept     (accept_w),
        .reject     (reject_w),
        .load       (load_w),
        .code       (code_w),
        .chan_field (chan_field_w),
        .go         (go_w),
        .enable     (en_w),
        .aen        (aen_w),
        .ext_ref    (ref_w),
        .result     (result_o),
        .ready      (ready_o),
        .irq        (irq_o),
        .rej_flag   (rej_w)
    );

    sar_fsm #(.N_CH(N_CH), .DATA_W(DATA_W), .SH_CYCLES(SH_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go_w),
        .enable     (en_w),
        .chan_field (chan_field_w),
        .aen        (aen_w),
        .ext_ref    (ref_w),
        .cmp_i      (cmp_i),
        .accept     (accept_w),
        .reject     (reject_w),
        .load       (load_w),
        .code       (code_w),
        .chan_o     (chan_o),
        .sh_o       (sh_o),
        .trial_o    (trial_o)
    );

    // pin 0 doubles as reference input, so its analog enable is masked then
    assign ana_en_o = aen_w & ~(N_CH'(ref_w));
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
`timescale 1ns/1ps
module sar_seq_ctrl_chk #(
    parameter int CH_W   = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              go,
    input logic              go_wr,
    input logic              enable,
    input logic              ext_ref,
    input logic [CH_W-1:0]   chan_o,
    input logic              sh_o,
    input logic [DATA_W-1:0] trial_o,
    input logic [DATA_W-1:0] result_o,
    input logic              ready_o,
    input logic              irq_o
);
    a_r3_go_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        go && !go_wr |=> !go);

    a_r4_no_trial_while_sampling: assert property (@(posedge clk) disable iff (!rst_n)
        sh_o |-> trial_o == '0);

    a_r5_ready_low_while_sampling: assert property (@(posedge clk) disable iff (!rst_n)
        sh_o |-> !ready_o);

    a_r6_result_moves_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> $rose(ready_o));

    a_r6_ready_brings_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> irq_o);

    a_r7_no_ch0_on_ext_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_o) |-> !($past(ext_ref) && chan_o == '0));

    a_r11_disable_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sh_o && trial_o == '0);
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.CH_W(CH_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go_w),
    .go_wr    (wr_en && (wr_addr == sar_pkg::ADDR_CTRL) && wr_data[sar_pkg::BIT_GO]),
    .enable   (en_w),
    .ext_ref  (ref_w),
    .chan_o   (chan_o),
    .sh_o     (sh_o),
    .trial_o  (trial_o),
    .result_o (result_o),
    .ready_o  (ready_o),
    .irq_o    (irq_o)
);

// File: tb/sar_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sar_seq_ctrl_tb;
    import sar_pkg::*;

    localparam int N_CH      = 8;
    localparam int CH_W      = 3;
    localparam int DATA_W    = 8;
    localparam int SH_CYCLES = 5;
    localparam int LAT       = SH_CYCLES + 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [1:0]        rd_addr = '0;
    logic [7:0]        rd_data;
    logic              cmp_i;
    logic [CH_W-1:0]   chan_o;
    logic              sh_o;
    logic [DATA_W-1:0] trial_o;
    logic [N_CH-1:0]   ana_en_o;
    logic [DATA_W-1:0] result_o;
    logic              ready_o;
    logic              irq_o;

    logic [DATA_W-1:0] vin [N_CH];
    logic [DATA_W-1:0] exp_q [$];
    logic [DATA_W-1:0] mon_e;
    logic [7:0]        rv;
    logic              prev_ready = 1'b0;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    // ideal comparator: input at or above trial code
    assign cmp_i = (vin[chan_o] >= trial_o);

    sar_seq_ctrl #(.N_CH(N_CH), .DATA_W(DATA_W), .SH_CYCLES(SH_CYCLES)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmp_i(cmp_i), .chan_o(chan_o), .sh_o(sh_o), .trial_o(trial_o),
        .ana_en_o(ana_en_o), .result_o(result_o), .ready_o(ready_o),
        .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    function automatic logic [7:0] ctrl(input int ch, input bit go, input bit en, input bit keep);
        logic [7:0] w;
        w = '0;
        w[2:0] = 3'(ch);
        w[BIT_GO] = go;
        w[BIT_EN] = en;
        w[BIT_IRQ] = keep;
        w[BIT_REJ] = keep;
        return w;
    endfunction

    task automatic watch(input int n, output int sh_seen);
        sh_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sh_o) sh_seen++;
        end
    endtask

    // driver: push expectation, start, follow the conversion
    task automatic convert(input int ch, input logic [7:0] v);
        int cyc = 0;
        int sh_n = 0;
        logic [7:0] prev_res;
        logic [7:0] r;
        vin[ch] = v;
        exp_q.push_back(v);
        prev_res = result_o;
        wr(ADDR_CTRL, ctrl(ch, 1'b1, 1'b1, 1'b0));
        rd(ADDR_CTRL, r);
        check(r[BIT_GO] == 1'b1, "R3", "start bit after write", r[BIT_GO], 1);
        do begin
            @(negedge clk);
            cyc++;
            if (sh_o) sh_n++;
            if (cyc == 1) begin
                rd(ADDR_CTRL, r);
                check(r[BIT_GO] == 1'b0, "R3", "start bit self-clear", r[BIT_GO], 0);
                check(!ready_o, "R5", "ready low during conversion", ready_o, 0);
                check(result_o == prev_res, "R5", "result kept during conversion", result_o, prev_res);
            end
            if (cyc == 2)
                check(chan_o == 3'(ch), "R1", "channel select", chan_o, ch);
            if (cyc == SH_CYCLES + 1)
                check(trial_o == 8'h80, "R4", "first trial code", trial_o, 8'h80);
        end while (!ready_o && cyc < 200);
        check(cyc == LAT, "R8", "completion latency", cyc, LAT);
        check(sh_n == SH_CYCLES, "R4", "sample strobe width", sh_n, SH_CYCLES);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (ready_o && !prev_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R10", "unexpected completion", result_o, 0);
                    end else begin
                        mon_e = exp_q.pop_front();
                        check(result_o == mon_e, "R4", "conversion result", result_o, mon_e);
                        check(irq_o, "R6", "irq with completion", irq_o, 1);
                    end
                end
                prev_ready = ready_o;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int s;
        for (int i = 0; i < N_CH; i++) vin[i] = 8'(i * 17 + 3);
        repeat (4) @(negedge clk);
        // R12 reset state
        check(!ready_o && !irq_o, "R12", "ready/irq after reset", {ready_o, irq_o}, 0);
        check(result_o == '0, "R12", "result after reset", result_o, 0);
        check(!sh_o && trial_o == '0, "R12", "strobe/trial after reset", trial_o, 0);
        rd(ADDR_CTRL, rv);
        check(rv == 8'h00, "R12", "control after reset", rv, 0);
        check(ana_en_o == '0, "R12", "analog enables after reset", ana_en_o, 0);
        rst_n = 1'b1;

        wr(ADDR_AEN, 8'hFF);
        // R1 R4 several codes and channels
        convert(3, 8'h5A);
        convert(0, 8'h00);
        convert(7, 8'hFF);
        convert(5, 8'h80);
        convert(2, 8'h7F);
        convert(6, 8'h01);

        // R9 irq sticky: writing 1 keeps, writing 0 clears
        check(irq_o, "R9", "irq set after completion", irq_o, 1);
        wr(ADDR_CTRL, ctrl(6, 1'b0, 1'b1, 1'b1));
        check(irq_o, "R9", "irq kept by writing 1", irq_o, 1);
        wr(ADDR_CTRL, ctrl(6, 1'b0, 1'b1, 1'b0));
        check(!irq_o, "R9", "irq cleared by writing 0", irq_o, 0);

        // R10 start while busy ignored
        vin[4] = 8'h33;
        vin[6] = 8'hC4;
        exp_q.push_back(8'h33);
        wr(ADDR_CTRL, ctrl(4, 1'b1, 1'b1, 1'b0));
        repeat (3) @(negedge clk);
        wr(ADDR_CTRL, ctrl(6, 1'b1, 1'b1, 1'b0));
        check(chan_o == 3'd4, "R10", "channel unchanged by busy start", chan_o, 4);
        watch(40, s);
        check(exp_q.size() == 0 && result_o == 8'h33, "R10", "single completion", result_o, 8'h33);

        // R11 disabled start: no conversion, no reject
        wr(ADDR_CTRL, ctrl(2, 1'b1, 1'b0, 1'b0));
        watch(30, s);
        check(s == 0, "R11", "no strobe when disabled", s, 0);
        rd(ADDR_CTRL, rv);
        check(rv[BIT_REJ] == 1'b0 && ready_o, "R11", "no reject, ready kept", rv, 8'h20);

        // R11 abort by clearing enable mid-conversion
        vin[2] = 8'h44;
        wr(ADDR_CTRL, ctrl(2, 1'b1, 1'b1, 1'b0));
        repeat (6) @(negedge clk);
        wr(ADDR_CTRL, ctrl(2, 1'b0, 1'b0, 1'b0));
        watch(30, s);
        check(!ready_o && !irq_o, "R11", "abort leaves ready/irq low", {ready_o, irq_o}, 0);
        check(result_o == 8'h33, "R11", "abort keeps result", result_o, 8'h33);
        check(!sh_o && trial_o == '0, "R11", "abort returns idle", trial_o, 0);

        // R2 disabled pin rejected
        wr(ADDR_AEN, 8'hF7);
        wr(ADDR_CTRL, ctrl(3, 1'b1, 1'b1, 1'b0));
        watch(25, s);
        check(s == 0, "R2", "no strobe on non-analog pin", s, 0);
        rd(ADDR_CTRL, rv);
        check(rv[BIT_REJ] == 1'b1, "R2", "reject flag set", rv[BIT_REJ], 1);
        wr(ADDR_CTRL, ctrl(3, 1'b0, 1'b1, 1'b1));
        rd(ADDR_CTRL, rv);
        check(rv[BIT_REJ] == 1'b1, "R9", "reject kept by writing 1", rv[BIT_REJ], 1);
        wr(ADDR_CTRL, ctrl(3, 1'b0, 1'b1, 1'b0));
        rd(ADDR_CTRL, rv);
        check(rv[BIT_REJ] == 1'b0, "R9", "reject cleared by writing 0", rv[BIT_REJ], 0);

        // R7 external reference
        wr(ADDR_AEN, 8'hFF);
        wr(ADDR_REF, 8'h01);
        check(ana_en_o == 8'hFE, "R7", "pin 0 enable masked", ana_en_o, 8'hFE);
        wr(ADDR_CTRL, ctrl(0, 1'b1, 1'b1, 1'b0));
        watch(25, s);
        check(s == 0, "R7", "no strobe on channel 0", s, 0);
        rd(ADDR_CTRL, rv);
        check(rv[BIT_REJ] == 1'b1, "R7", "reject on channel 0", rv[BIT_REJ], 1);
        convert(1, 8'h9C);
        wr(ADDR_REF, 8'h00);
        check(ana_en_o == 8'hFF, "R7", "pin 0 enable restored", ana_en_o, 8'hFF);
        convert(0, 8'hE1);

        watch(5, s);
        check(exp_q.size() == 0, "R6", "all expected results seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule